// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a 32-bit physical address by walking a two-level page table that lives in memory. It splits the address into three fields. The top 10 bits index an outer directory. The next 10 bits index an inner table. The low 12 bits are the byte offset within a 4 KB page. Two levels are used because one flat table covering 2^20 pages would need 4 MB of 4-byte entries. With two levels, only the inner tables that are actually populated need to exist.

A walk starts with a one-cycle `start` pulse carrying the linear address, while `root_base` holds the directory location.

1. The walker reads the directory entry through a word-wide read port.
2. If that entry is valid, it reads the entry in the inner table.
3. It then reports the frame base joined with the offset and pulses `done`.

Every entry is 32 bits: bit 0 is the valid flag, and bits 31:12 hold a 4 KB-aligned base. An entry with a clear valid bit at either level ends the walk with `fault` raised alongside `done`. Read responses may arrive after any number of cycles.

Top module: `pt_walk2`

## Requirements
- R1: After reset, `busy`, `done`, `fault` and `mem_req` are all low.
- R2: One cycle after an accepted `start`, `mem_req` is high. `mem_addr` equals `{root_base[31:12],12'h000} + 4*va[31:22]`.
- R3: When a directory response has bit 0 set, the next cycle shows `mem_req` high. `mem_addr` equals `{dir_entry[31:12],12'h000} + 4*va[21:12]`.
- R4: When a table response has bit 0 set, the next cycle shows `done` high for exactly one cycle and `fault` low. In that cycle `pa` equals `{tbl_entry[31:12], va[11:0]}`.
- R5: When a directory response has bit 0 clear, the next cycle shows `done` and `fault` both high for one cycle, with `pa` equal to 0. No table read is issued.
- R6: When a table response has bit 0 clear, the next cycle shows `done` and `fault` both high for one cycle, with `pa` equal to 0.
- R7: While `mem_req` is high and `mem_rvalid` is low, the request and its address are held in the next cycle. This lets a response come any number of cycles later, including in the first request cycle.
- R8: A `start` arriving while `busy` is high is ignored. The outstanding address and the final result still follow the original walk.
- R9: `busy` is high from the cycle after an accepted `start` through the `done` cycle. `mem_req` is never high while `done` is high.
- R10: A `mem_rvalid` pulse while no request is outstanding has no effect. `done` stays low and no read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_base | input | 32 | Directory location; bits 31:12 are used |
| start | input | 1 | Begin a walk; accepted only while idle |
| va | input | 32 | Linear address, sampled with `start` |
| busy | output | 1 | Walk in progress |
| mem_req | output | 1 | Read request, held until a response |
| mem_addr | output | 32 | Byte address of the entry being read |
| mem_rvalid | input | 1 | Read data strobe |
| mem_rdata | input | 32 | Entry returned by memory |
| pa | output | 32 | Translated physical address |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Set with `done` when an entry was invalid |

## Verification
The in-line assertions check on every cycle the protocol properties:
- the request is held with a stable address until its response arrives;
- `done` lasts one cycle and never overlaps a request;
- `fault` never appears without `done`;
- a late `start` leaves the outstanding address untouched;
- an invalid directory entry leads straight to a fault.

Only the bench's scenarios can show the arithmetic: the exact directory and table entry addresses, and the assembled physical address for particular entries and offsets. The same holds for latency independence across zero-wait and long-wait responses, and for the harmlessness of stray responses while idle.

// File: rtl/pt_walk2.sv
module pt_walk2 #(
  parameter int DIR_BITS = 10,
  parameter int TBL_BITS = 10,
  parameter int OFF_BITS = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] root_base,
  input  logic        start,
  input  logic [31:0] va,
  output logic        busy,
  output logic        mem_req,
  output logic [31:0] mem_addr,
  input  logic        mem_rvalid,
  input  logic [31:0] mem_rdata,
  output logic [31:0] pa,
  output logic        done,
  output logic        fault
);
  localparam int AW = DIR_BITS + TBL_BITS + OFF_BITS;
  localparam int FW = AW - OFF_BITS;

  typedef enum logic [2:0] {S_IDLE, S_DIR, S_TBL, S_DONE, S_FAULT} st_t;
  st_t st;

  logic [AW-1:0] va_q;
  logic [FW-1:0] root_q, tbl_q;
  logic [AW-1:0] pa_q;

  wire [DIR_BITS-1:0] dir_idx = va_q[AW-1 -: DIR_BITS];
  wire [TBL_BITS-1:0] tbl_idx = va_q[OFF_BITS+TBL_BITS-1 -: TBL_BITS];
  wire entry_ok = mem_rdata[0];

  wire [AW-1:0] dir_ea = {root_q, {OFF_BITS{1'b0}}}
                       + {{(AW-DIR_BITS-2){1'b0}}, dir_idx, 2'b00};
  wire [AW-1:0] tbl_ea = {tbl_q, {OFF_BITS{1'b0}}}
                       + {{(AW-TBL_BITS-2){1'b0}}, tbl_idx, 2'b00};

  assign busy     = (st != S_IDLE);
  assign mem_req  = (st == S_DIR) || (st == S_TBL);
  assign mem_addr = (st == S_TBL) ? tbl_ea : dir_ea;
  assign done     = (st == S_DONE) || (st == S_FAULT);
  assign fault    = (st == S_FAULT);
  assign pa       = pa_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      va_q   <= '0;
      root_q <= '0;
      tbl_q  <= '0;
      pa_q   <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (start) begin
          va_q   <= va;
          root_q <= root_base[AW-1:OFF_BITS];
          st     <= S_DIR;
        end
        S_DIR: if (mem_rvalid) begin
          if (entry_ok) begin
            tbl_q <= mem_rdata[AW-1:OFF_BITS];
            st    <= S_TBL;
          end else begin
            pa_q <= '0;
            st   <= S_FAULT;
          end
        end
        S_TBL: if (mem_rvalid) begin
          if (entry_ok) begin
            pa_q <= {mem_rdata[AW-1:OFF_BITS], va_q[OFF_BITS-1:0]};
            st   <= S_DONE;
          end else begin
            pa_q <= '0;
            st   <= S_FAULT;
          end
        end
        S_DONE:  st <= S_IDLE;
        S_FAULT: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_hold_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_rvalid |=> mem_req && $stable(mem_addr));

  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_fault_with_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> done);

  assert_dir_invalid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !$past(mem_req) && mem_rvalid && !mem_rdata[0]) |=> fault && !mem_req);

  assert_no_req_at_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_req && busy);

  assert_late_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_rvalid && start |=> $stable(mem_addr));

  assert_idle_rvalid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !start && mem_rvalid |=> !busy && !done);
endmodule

// File: tb/sim_pt_walk2.sv
`timescale 1ns/1ps
module sim_pt_walk2;
  logic clk = 0, rst_n = 0;
  logic [31:0] root_base = 32'h0001_0000, va = 0, mem_rdata = 0;
  logic start = 0, mem_rvalid = 0;
  logic busy, mem_req, done, fault;
  logic [31:0] mem_addr, pa;
  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  pt_walk2 u0 (.clk, .rst_n, .root_base, .start, .va, .busy, .mem_req,
    .mem_addr, .mem_rvalid, .mem_rdata, .pa, .done, .fault);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one walk; l1/l2 = wait cycles before each response; late = inject start while waiting
  task automatic walk(input logic [31:0] v, input logic [31:0] de, input logic [31:0] te,
                      input int l1, input int l2, input bit late);
    logic [31:0] dea, tea;
    dea = {root_base[31:12], 12'h000} + {20'd0, v[31:22], 2'b00};
    tea = {de[31:12], 12'h000} + {20'd0, v[21:12], 2'b00};
    @(negedge clk); start = 1; va = v;
    @(negedge clk); start = 0;
    chk(mem_req && busy, "R9", {31'd0, mem_req}, 32'd1);
    chk(mem_addr == dea, "R2", mem_addr, dea);
    for (int i = 0; i < l1; i++) begin
      if (late && i == 0) begin start = 1; va = ~v; end
      @(negedge clk); start = 0;
      chk(mem_req && mem_addr == dea, late ? "R8" : "R7", mem_addr, dea);
    end
    mem_rdata = de; mem_rvalid = 1;
    @(negedge clk); mem_rvalid = 0;
    if (!de[0]) begin
      chk(done && fault && !mem_req, "R5", {done, fault, mem_req}, 3'b110);
      chk(pa == 0, "R5", pa, 0);
    end else begin
      chk(mem_req && mem_addr == tea, "R3", mem_addr, tea);
      for (int i = 0; i < l2; i++) begin
        @(negedge clk);
        chk(mem_req && mem_addr == tea, "R7", mem_addr, tea);
      end
      mem_rdata = te; mem_rvalid = 1;
      @(negedge clk); mem_rvalid = 0;
      if (!te[0]) begin
        chk(done && fault, "R6", {done, fault}, 2'b11);
        chk(pa == 0, "R6", pa, 0);
      end else begin
        chk(done && !fault && !mem_req, "R4", {done, fault, mem_req}, 3'b100);
        chk(pa == {te[31:12], v[11:0]}, late ? "R8" : "R4", pa, {te[31:12], v[11:0]});
      end
    end
    @(negedge clk);
    chk(!done && !busy, "R4", {done, busy}, 0);
  endtask

  task automatic t_reset();
    chk(!busy && !done && !fault && !mem_req, "R1", {busy, done, fault, mem_req}, 0);
  endtask

  task automatic t_stray();
    @(negedge clk); mem_rdata = 32'hFFFF_FFFF; mem_rvalid = 1;
    @(negedge clk); mem_rvalid = 0;
    chk(!done && !busy && !mem_req, "R10", {done, busy, mem_req}, 0);
    @(negedge clk);
    chk(!done && !busy, "R10", {done, busy}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    walk(32'h0040_3ABC, 32'h0020_0001, 32'h1234_5001, 0, 0, 0);
    walk(32'hFFFF_FFFF, 32'hABCD_E003, 32'h8765_4FFF, 3, 5, 0);
    walk(32'h0000_0000, 32'h0000_1001, 32'h0000_2001, 1, 0, 0);
    walk(32'h1234_5678, 32'h0030_0000, 32'h0, 2, 0, 0);
    walk(32'h8000_1004, 32'h0050_0001, 32'h0060_0000, 0, 4, 0);
    walk(32'h0C00_3FF0, 32'h0070_0001, 32'h0099_9001, 4, 1, 1);
    root_base = 32'hFFFF_FABC;
    walk(32'hFFC0_0123, 32'h0001_0001, 32'hCAFE_B001, 0, 2, 0);
    t_stray();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule